// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block sits between a driver-impedance calibration engine and the output drivers of a memory interface. The calibration engine offers a fresh impedance code from time to time. The scheduler lets a code reach the drivers only while the data outputs are idle, which here means high impedance. A code that arrives while the outputs are driving is parked in a single holding register. When several codes arrive before the next idle window, only the newest one is kept. Each code that reaches the drivers is marked by a one-cycle update pulse.

Calibration counts as settled only after two things have happened, in this order. First, a long power-up wait of `PWRUP_CYCLES` clocks must finish; the default is 8192. Second, at least one idle-output cycle must follow that wait. The ready flag then stays set until the next reset. The synchronous reset also stands for power-up. It restarts the wait and loads a mid-scale code.

Top module: `imp_update_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `z_code` equals the mid-scale value 1 << (CODE_W-1), `z_update` is 0, `z_ready` is 0 and no code is held.
- R2: `z_code` changes only at a clock edge that ends a cycle in which `drv_idle` was 1.
- R3: A code offered with `cal_vld`=1 while `drv_idle`=0 is held. It is applied at the edge that ends the first later cycle with `drv_idle`=1. `z_update` is 1 in the cycle after that edge.
- R4: When several codes are offered while the outputs drive, only the last one is applied, with a single update pulse.
- R5: A code offered in a cycle with `drv_idle`=1 is applied at that cycle's edge. It takes precedence over any held code, and that held code is discarded.
- R6: `z_update` is 1 for exactly one cycle for each applied code, and it is never 1 without an applied code.
- R7: The power-up counter saturates at its terminal value. `z_ready` stays 0 for the first `PWRUP_CYCLES` cycles after reset, whatever `drv_idle` does.
- R8: `z_ready` rises at the edge that ends the first cycle that has both the power-up count complete (at least `PWRUP_CYCLES`-1 cycles since reset) and `drv_idle`=1. While the outputs keep driving, it waits.
- R9: Once set, `z_ready` stays 1 until reset. A reset clears it and restarts the power-up count.
- R10: Applying a code consumes it. Later idle cycles with no new code give no further update pulse and leave `z_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset / power-up indication |
| drv_idle | input | 1 | Data output drivers are high impedance this cycle |
| cal_vld | input | 1 | New code from the calibration engine is valid |
| cal_code | input | CODE_W | Offered impedance code |
| z_code | output | CODE_W | Impedance code applied to the drivers |
| z_update | output | 1 | One-cycle pulse per applied code |
| z_ready | output | 1 | Calibration settled flag |

## Verification
Two collisions can happen in the same cycle. A new code can arrive in the very cycle an idle window opens while an older code is still held. The power-up count can also reach its terminal value in a cycle whose idle state decides when the ready flag rises. The bench provokes the first collision directly, and also many times through random idle and valid patterns. It provokes the second by holding the outputs driving across the terminal count and then releasing them. A cycle-accurate reference model built from the requirements predicts the code, pulse and ready flag each cycle, and every cycle is compared against it.

// File: rtl/imp_sched_pkg.sv
package imp_sched_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_LIVE = 2'd2
    } upd_src_e;

    // A live code beats a held one; nothing is applied while the outputs drive.
    function automatic upd_src_e pick_source(input logic idle,
                                             input logic live_vld,
                                             input logic held_vld);
        if (!idle)
            return SRC_NONE;
        if (live_vld)
            return SRC_LIVE;
        if (held_vld)
            return SRC_HELD;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/imp_pwrup_timer.sv
module imp_pwrup_timer #(
    parameter int PWRUP_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst,
    output logic count_done
);
    localparam int CNT_W = (PWRUP_CYCLES > 2) ? $clog2(PWRUP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(PWRUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != TERM)
            cnt <= cnt + 1'b1;
    end

    assign count_done = (cnt == TERM);

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        count_done |=> count_done);                                   // R7
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(count_done)) |-> (cnt == $past(cnt) + 1'b1)); // R7

endmodule

// File: rtl/imp_code_stage.sv
module imp_code_stage
    import imp_sched_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              live_vld,
    input  logic [CODE_W-1:0] live_code,
    output logic [CODE_W-1:0] code_out,
    output logic              upd_pulse
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] held_code;
    logic              held_vld;
    upd_src_e          src;

    assign src = pick_source(idle, live_vld, held_vld);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_code <= MID_CODE;
            held_vld  <= 1'b0;
            code_out  <= MID_CODE;
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= (src != SRC_NONE);
            case (src)
                SRC_LIVE: begin
                    code_out <= live_code;
                    held_vld <= 1'b0;
                end
                SRC_HELD: begin
                    code_out <= held_code;
                    held_vld <= 1'b0;
                end
                default: begin
                    if (live_vld) begin
                        held_code <= live_code;
                        held_vld  <= 1'b1;
                    end
                end
            endcase
        end
    end

    AST_CODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && code_out != $past(code_out)) |-> $past(idle));   // R2
    AST_PULSE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> $past(idle));                                      // R6
    AST_HELD_CLEARED: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> !held_vld);                                        // R10
    AST_HELD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (held_vld && !idle) |=> held_vld);                               // R3

endmodule

// File: rtl/imp_ready_track.sv
module imp_ready_track (
    input  logic clk,
    input  logic rst,
    input  logic count_done,
    input  logic idle,
    output logic ready
);
    always_ff @(posedge clk) begin
        if (rst)
            ready <= 1'b0;
        else if (count_done && idle)
            ready <= 1'b1;
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);                                                // R9
    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(count_done) && $past(idle)));            // R8

endmodule

// File: rtl/imp_update_sched.sv
module imp_update_sched #(
    parameter int CODE_W       = 6,
    parameter int PWRUP_CYCLES = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_idle,
    input  logic              cal_vld,
    input  logic [CODE_W-1:0] cal_code,
    output logic [CODE_W-1:0] z_code,
    output logic              z_update,
    output logic              z_ready
);
    logic count_done;

    imp_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .count_done (count_done)
    );

    imp_code_stage #(.CODE_W(CODE_W)) u_code (
        .clk       (clk),
        .rst       (rst),
        .idle      (drv_idle),
        .live_vld  (cal_vld),
        .live_code (cal_code),
        .code_out  (z_code),
        .upd_pulse (z_update)
    );

    imp_ready_track u_ready (
        .clk        (clk),
        .rst        (rst),
        .count_done (count_done),
        .idle       (drv_idle),
        .ready      (z_ready)
    );

    AST_READY_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
        z_ready |-> count_done);                                         // R7

endmodule

// File: tb/tb_imp_update_sched.sv
module tb_imp_update_sched;
    localparam int CW = 6;
    localparam int PW = 8192;
    localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst;
    logic          drv_idle;
    logic          cal_vld;
    logic [CW-1:0] cal_code;
    logic [CW-1:0] z_code;
    logic          z_update;
    logic          z_ready;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [CW-1:0] m_code, m_held;
    logic          m_held_vld, m_pulse, m_ready;
    int            m_idx;

    always #10 clk = ~clk;

    imp_update_sched #(.CODE_W(CW), .PWRUP_CYCLES(PW)) dut (
        .clk(clk), .rst(rst), .drv_idle(drv_idle), .cal_vld(cal_vld),
        .cal_code(cal_code), .z_code(z_code), .z_update(z_update), .z_ready(z_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic count_complete(input int idx);
        return idx >= PW - 1;
    endfunction

    task automatic model_step(input logic r, input logic h, input logic v, input logic [CW-1:0] c);
        if (r) begin
            m_code = MID; m_held = MID; m_held_vld = 0; m_pulse = 0; m_ready = 0; m_idx = 0;
        end else begin
            if (count_complete(m_idx) && h) m_ready = 1;
            m_idx++;
            if (h && v) begin
                m_code = c; m_pulse = 1; m_held_vld = 0;
            end else if (h && m_held_vld) begin
                m_code = m_held; m_pulse = 1; m_held_vld = 0;
            end else begin
                m_pulse = 0;
                if (v) begin m_held = c; m_held_vld = 1; end
            end
        end
    endtask

    task automatic step(input logic r, input logic h, input logic v, input logic [CW-1:0] c);
        rst = r; drv_idle = h; cal_vld = v; cal_code = c;
        model_step(r, h, v, c);
        @(posedge clk);
        #1;
        check("R2 code", int'(z_code), int'(m_code));
        check("R6 pulse", int'(z_update), int'(m_pulse));
        check("R8 ready", int'(z_ready), int'(m_ready));
        @(negedge clk);
    endtask

    task automatic rand_step(input int idle_pct);
        logic h, v;
        h = ($urandom % 100) < idle_pct;
        v = ($urandom % 4) == 0;
        step(1'b0, h, v, CW'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1; drv_idle = 0; cal_vld = 0; cal_code = '0;
        repeat (3) step(1, 1, 1, 6'd7);
        check("R1 reset code", int'(z_code), int'(MID));
        check("R1 reset pulse", int'(z_update), 0);
        check("R1 reset ready", int'(z_ready), 0);

        // R3/R4: codes arrive while driving, last wins
        step(0, 0, 1, 6'd5);
        step(0, 0, 1, 6'd9);
        step(0, 0, 1, 6'd17);
        repeat (3) step(0, 0, 0, 6'd0);
        check("R3 held while driving", int'(z_code), int'(MID));
        step(0, 1, 0, 6'd0);
        check("R4 last code applied", int'(z_code), 17);
        check("R3 pulse on idle", int'(z_update), 1);
        repeat (2) step(0, 1, 0, 6'd0);
        check("R10 no repeat pulse", int'(z_update), 0);
        check("R10 code kept", int'(z_code), 17);

        // R5: live code in idle cycle beats held code
        step(0, 0, 1, 6'd3);
        step(0, 1, 1, 6'd40);
        check("R5 live wins", int'(z_code), 40);
        step(0, 1, 0, 6'd0);
        check("R5 held discarded", int'(z_update), 0);
        check("R5 code stays", int'(z_code), 40);

        // random traffic before count completes
        for (int i = 0; i < 7800; i++) rand_step(50);
        check("R7 not ready early", int'(z_ready), 0);

        // hold outputs driving across the terminal count
        for (int i = 0; i < 500; i++) step(0, 0, ($urandom % 8) == 0, CW'($urandom));
        check("R8 waits for idle", int'(z_ready), 0);
        step(0, 1, 0, 6'd0);
        check("R8 ready after idle", int'(z_ready), 1);

        for (int i = 0; i < 300; i++) rand_step(30);
        check("R9 sticky", int'(z_ready), 1);

        // mid-run reset
        repeat (2) step(1, 0, 1, 6'd11);
        check("R9 reset clears ready", int'(z_ready), 0);
        check("R1 reset reload", int'(z_code), int'(MID));
        for (int i = 0; i < 400; i++) rand_step(80);
        check("R7 count restarted", int'(z_ready), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule